// File: doc/BRIEF.md
# Word-Fed Transmit Frame Buffer

This block sits between a software-visible data register and a byte-serial transmit path. Software writes a frame into a 2048-byte buffer as 32-bit words. The low half of the first word is the payload length. The remaining bytes are the frame itself, starting at buffer byte 2.

The block continuously judges two things: whether the buffer holds a whole frame, and whether the programmable fill threshold has been reached. When both hold, or when software forces a send, it streams the frame out one byte at a time on a valid/ready interface with a last marker. It can pad short frames with zeros. After the final byte it clears the buffer and pulses an empty event. A length word that is too large is refused with an error pulse. A flush strobe empties the buffer at any time.

Top module: `tx_frame_buf`

## Requirements
- R1: Words are stored little-endian: byte j of a word (bits 8j+7..8j) lands at buffer byte 4k+j for the k-th word written, and the output stream emits buffer bytes in ascending address order.
- R2: When the fill level is zero, the low 16 bits of an accepted write are the payload length. A value above 2032 is discarded, and `tx_err` is high for exactly the cycle after that write. A value of 2032 is stored with no error.
- R3: A word is stored only when the fill level is at most 2044, so at least four bytes are free. A write to a full buffer leaves the buffer contents unchanged.
- R4: A frame is complete when the fill level is nonzero and at least length+16 with `crc_auto`=1, or at least length+20 with `crc_auto`=0. The requirement is capped at 2048.
- R5: The 6-bit threshold register resets to 63 and is loaded from `thr_data` when `thr_wr` is high. A value of 63 disables automatic sending. Any other value t is met when the fill level is at least 32*t+4.
- R6: Sending starts automatically in the cycle after the threshold is met and the frame is complete. `send_req` high while idle starts a send regardless of fill.
- R7: The sent frame is buffer bytes from address 2 onward, length+14 bytes long. With `pad_en`=1 and a length under 60, it is extended with zero bytes to 60. The total is capped at 2046. `m_last` marks the final byte. `m_data` and `m_valid` hold while `m_ready` is low.
- R8: After the final byte is accepted, the fill level is zero and `tx_empty` is high for exactly one cycle.
- R9: `flush` zeroes the fill level, and a write in the same cycle is dropped.
- R10: `busy` is high from the cycle a send is decided until the final byte is accepted. Word writes while `busy` is high are not accepted.
- R11: After reset, `m_valid`, `busy`, `tx_err` and `tx_empty` are low and the fill level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 32 | Word to store |
| pad_en | input | 1 | Pad short frames to 60 bytes |
| crc_auto | input | 1 | CRC added downstream (no CRC bytes in the buffer) |
| thr_wr | input | 1 | Load the threshold register |
| thr_data | input | 6 | New threshold value |
| send_req | input | 1 | Force a send |
| flush | input | 1 | Empty the buffer |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the byte |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Final byte of the frame |
| busy | output | 1 | Send decided or in progress |
| tx_err | output | 1 | Oversized length refused (pulse) |
| tx_empty | output | 1 | Frame finished, buffer empty (pulse) |

## Verification
A wrong fill level shows up at the ports as `busy` rising at the wrong word count. It is visible within one cycle of the offending write, because the send decision is combinational on the stored level. A wrong length register or wrong byte addressing shows up in the streamed frame: its byte count, its first bytes, or its padding. A stale fill after a send or flush makes the next frame trigger early. Because of that, every frame is followed by another whose trigger point is checked.

// File: rtl/tx_frame_buf.sv
module tx_frame_buf #(
  parameter int BUF_BYTES = 2048,
  parameter int MAX_LEN   = 2032,
  parameter int MIN_FRAME = 60,
  parameter int HDR_BYTES = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        pad_en,
  input  logic        crc_auto,
  input  logic        thr_wr,
  input  logic [5:0]  thr_data,
  input  logic        send_req,
  input  logic        flush,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [7:0]  m_data,
  output logic        m_last,
  output logic        busy,
  output logic        tx_err,
  output logic        tx_empty
);
  localparam int WORDS    = BUF_BYTES / 4;
  localparam int AW       = $clog2(WORDS);
  localparam int FW       = $clog2(BUF_BYTES) + 1;
  localparam int MAX_SEND = BUF_BYTES - 2;

  logic [31:0]   mem [WORDS];
  logic [FW-1:0] fill, cnt, tot, raw_q, addr;
  logic [15:0]   len_q;
  logic [5:0]    thr_q;
  logic          sending;

  logic        first, too_long, has_room, accept, complete, thr_met;
  logic        auto_go, go, hs, fin;
  logic [16:0] fill17, need_raw, need, thr_need, raw, padded, sendlen;
  logic [31:0] word;

  assign fill17   = 17'(fill);
  assign first    = (fill == '0);
  assign too_long = first && (wr_data[15:0] > 16'(MAX_LEN));
  assign has_room = fill17 <= 17'(BUF_BYTES - 4);
  assign busy     = sending | go;
  assign accept   = wr_en && !busy && !flush && !too_long && has_room;

  assign need_raw = {1'b0, len_q} + (crc_auto ? 17'd16 : 17'd20);
  assign need     = (need_raw > 17'(BUF_BYTES)) ? 17'(BUF_BYTES) : need_raw;
  assign complete = !first && (fill17 >= need);
  assign thr_need = 17'({thr_q, 5'b0}) + 17'd4;
  assign thr_met  = (thr_q != 6'h3f) && (fill17 >= thr_need);
  assign auto_go  = !sending && thr_met && complete;
  assign go       = auto_go || (!sending && send_req);

  assign raw     = {1'b0, len_q} + 17'(HDR_BYTES);
  assign padded  = (pad_en && raw < 17'(MIN_FRAME)) ? 17'(MIN_FRAME) : raw;
  assign sendlen = (padded > 17'(MAX_SEND)) ? 17'(MAX_SEND) : padded;

  assign m_valid = sending;
  assign m_last  = sending && (cnt == tot - 1'b1);
  assign hs      = m_valid && m_ready;
  assign fin     = hs && m_last;
  assign addr    = cnt + FW'(2);
  assign word    = mem[addr[AW+1:2]];
  assign m_data  = (cnt >= raw_q) ? 8'h00 : word[8*addr[1:0] +: 8];

  always_ff @(posedge clk) begin
    if (accept) mem[fill[AW+1:2]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill     <= '0;
      len_q    <= '0;
      thr_q    <= 6'h3f;
      sending  <= 1'b0;
      cnt      <= '0;
      tot      <= '0;
      raw_q    <= '0;
      tx_err   <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      tx_err   <= wr_en && !busy && !flush && too_long;
      tx_empty <= fin;
      if (thr_wr) thr_q <= thr_data;
      if (flush || fin) begin
        fill <= '0;
      end else if (accept) begin
        fill <= fill + FW'(4);
        if (first) len_q <= wr_data[15:0];
      end
      if (go) begin
        sending <= 1'b1;
        cnt     <= '0;
        tot     <= FW'(sendlen);
        raw_q   <= FW'(raw);
      end else if (hs) begin
        if (m_last) sending <= 1'b0;
        else        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill17 <= 17'(BUF_BYTES)); // R3
  AST_ERR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (fill == '0) && !m_valid); // R2
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data)); // R7
  AST_EMPTY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> tx_empty && (fill == '0)); // R8
  AST_NO_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sending && !flush && !fin |=> fill == $past(fill)); // R10
endmodule

// File: tb/sim_tx_frame_buf.sv
module sim_tx_frame_buf;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, pad_en = 0, crc_auto = 1, thr_wr = 0, send_req = 0, flush = 0;
  logic m_ready = 1, bp = 0;
  logic [31:0] wr_data = 0;
  logic [5:0]  thr_data = 0;
  logic m_valid, m_last, busy, tx_err, tx_empty;
  logic [7:0] m_data;

  int checks = 0, fails = 0;
  int got [2048];
  int gotn = 0, frames = 0, empties = 0;

  always #10 clk = ~clk;

  tx_frame_buf u0 (.*);

  localparam int NV = 5;
  localparam int V_LEN [NV] = '{4, 4, 10, 46, 100};
  localparam int V_PAD [NV] = '{0, 1, 0, 1, 0};
  localparam int V_CRC [NV] = '{1, 1, 0, 1, 1};
  localparam int V_THR [NV] = '{0, 0, 2, 0, 1};
  localparam int V_WRD [NV] = '{5, 5, 17, 16, 29};
  localparam int V_BYT [NV] = '{18, 60, 24, 60, 114};

  always @(negedge clk) begin
    m_ready = bp ? ~m_ready : 1'b1;
    #5;
    if (tx_empty) empties++;
    if (m_valid && m_ready) begin
      got[gotn] = m_data;
      gotn++;
      if (m_last) frames++;
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [31:0] wordk(int k, int len);
    logic [31:0] w;
    w = {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)};
    if (k == 0) w[15:0] = 16'(len);
    return w;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_word(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    #5;
  endtask

  task automatic set_thr(int t);
    @(negedge clk); thr_wr = 1; thr_data = 6'(t);
    @(negedge clk); thr_wr = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic pulse_send();
    @(negedge clk); send_req = 1;
    @(negedge clk); send_req = 0;
  endtask

  task automatic fill_frame(int len, int maxw, output int taken);
    taken = maxw;
    for (int k = 0; k < maxw; k++) begin
      wr_word(wordk(k, len));
      if (busy) begin taken = k + 1; break; end
    end
  endtask

  task automatic expect_frame(int len, int nbytes, string tag);
    int f0, e0, bad;
    f0 = frames; e0 = empties;
    for (int c = 0; c < 6000 && frames == f0; c++) @(negedge clk);
    repeat (2) @(negedge clk);
    #6;
    chk(gotn == nbytes, {tag, " byte count"}, gotn, nbytes);
    bad = -1;
    for (int i = 0; i < gotn && i < nbytes; i++) begin
      int e;
      e = (i < len + 14) ? int'(pat(i + 2)) : 0;
      if (got[i] != e && bad < 0) bad = i;
    end
    chk(bad < 0, {tag, " first bad byte index"}, bad, -1);
    chk(empties - e0 == 1, {tag, " R8 tx_empty pulses"}, empties - e0, 1);
    gotn = 0;
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    // R11 reset state
    chk(!m_valid && !busy && !tx_err && !tx_empty, "R11 reset outputs", {m_valid, busy, tx_err, tx_empty}, 0);

    // R5 threshold resets to 63: complete frame does not auto-send; R6 manual send
    fill_frame(4, 6, w);
    chk(w == 6 && !busy, "R5 no auto send at reset threshold", w, 6);
    pulse_send();
    expect_frame(4, 18, "R6 manual send");

    // table walk: R1 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      pad_en = V_PAD[v][0]; crc_auto = V_CRC[v][0];
      set_thr(V_THR[v]);
      fill_frame(V_LEN[v], 40, w);
      chk(w == V_WRD[v], $sformatf("R4 R6 vector %0d trigger words", v), w, V_WRD[v]);
      expect_frame(V_LEN[v], V_BYT[v], $sformatf("R1 R7 vector %0d", v));
    end

    // R2 oversized length refused and discarded
    pad_en = 0; crc_auto = 1; set_thr(0);
    wr_word(32'h0000_07F1);
    chk(tx_err == 1, "R2 tx_err on 2033", tx_err, 1);
    @(negedge clk); #5;
    chk(tx_err == 0, "R2 tx_err one cycle", tx_err, 0);
    fill_frame(4, 10, w);
    chk(w == 5, "R2 word discarded trigger", w, 5);
    expect_frame(4, 18, "R2 frame after error");

    // R2 length 2032 accepted; R9 flush
    set_thr(63);
    wr_word(32'h0000_07F0);
    chk(tx_err == 0, "R2 2032 accepted", tx_err, 0);
    wr_word(wordk(1, 0)); wr_word(wordk(2, 0));
    pulse_flush();
    set_thr(0);
    fill_frame(4, 10, w);
    chk(w == 5, "R9 flush zeroes fill", w, 5);
    expect_frame(4, 18, "R9 frame after flush");

    // R7 backpressure with padding; R10 busy and write ignored
    pad_en = 1; crc_auto = 1; bp = 1;
    fill_frame(10, 10, w);
    chk(w == 7, "R4 len10 trigger words", w, 7);
    wr_word(32'hFFFF_FFFF);
    chk(busy == 1, "R10 busy during stream", busy, 1);
    expect_frame(10, 60, "R7 backpressure pad");
    bp = 0;
    fill_frame(4, 10, w);
    chk(w == 5, "R10 write during busy not kept", w, 5);
    expect_frame(4, 60, "R10 next frame");

    // R4 cap at 2048 with crc_auto off
    pad_en = 0; crc_auto = 0;
    fill_frame(2032, 513, w);
    chk(w == 512, "R4 capped completion", w, 512);
    expect_frame(2032, 2046, "R7 max frame");

    // R3 write to full buffer dropped
    crc_auto = 1; set_thr(63);
    fill_frame(2032, 512, w);
    wr_word(32'hDEAD_BEEF);
    chk(!busy, "R3 no send while disabled", busy, 0);
    pulse_send();
    expect_frame(2032, 2046, "R3 full buffer unchanged");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule